// File: doc/BRIEF.md
# Legacy I2C Target Engine

This block lets a device on a shared I3C/I2C bus answer plain 7-bit I2C private transfers aimed at its static address. SCL and SDA arrive as raw pad samples and are synchronized to the system clock. The engine finds Start, repeated Start and Stop conditions, collects the address header and then either acknowledges it or stays silent. After an acknowledged write header, each received byte goes into a one-byte receive buffer. After an acknowledged read header, the engine shifts out the byte that firmware placed in a one-byte transmit buffer. The engine drives SDA only by pulling it low, through an open-drain enable.

The block answers to its static address only in legacy mode. It leaves legacy mode when a dynamic address is held or when the static-address SDR option is on; in that case every header carrying the static address is rejected. Firmware sees sticky event flags and a sticky two-bit direction code. Firmware also controls the acknowledge through a standing polarity input and a one-shot override that applies to a single response. Transfer length limits have no effect in legacy mode, so the engine has no length limit.

Top module: `i2c_legacy_target`

## Requirements
- R1: A header whose 7 address bits (sent MSB first, followed by R/W where 1 means read) equal `static_addr_i` is acknowledged in legacy mode, and `addr_match_o` is set.
- R2: Legacy mode holds when both `dyn_addr_valid_i` and `sa_sdr_en_i` are 0, and `mode_o` then reads 2'b00; otherwise `mode_o` reads 2'b01. A header is left unacknowledged, and `addr_match_o` stays clear, if it carries a different address or arrives outside legacy mode.
- R3: An accepted header loads `dir_o` with 2'b10 for a write or 2'b01 for a read. The code holds after the transfer ends, until `flag_clr_i` clears it to 2'b00 or the next accepted header overwrites it.
- R4: In a write transfer, each byte that arrives while the receive buffer is empty is stored in `rx_data_o` and acknowledged, and `rx_full_o` is set. `rx_pop_i` empties the buffer.
- R5: A write byte that arrives while `rx_full_o` is 1 is not acknowledged and is not stored, and `rx_over_o` is set.
- R6: A read header is acknowledged only if the transmit buffer holds a byte. The first data byte is the byte in the transmit buffer, sent MSB first, and `tx_empty_o` returns to 1 once that byte is taken.
- R7: A controller ACK after a read byte sets `cack_o`, and the next byte follows. If the transmit buffer is empty at that point, the byte sent is 8'hFF and `tx_under_o` is set.
- R8: A controller NACK after a read byte sets `cnack_o`. The engine then keeps SDA released until a Stop or a repeated Start.
- R9: A Stop or a repeated Start that ends a transfer whose header was acknowledged sets `tcomp_o`.
- R10: With the one-shot override disarmed, `ack_pol_i` = 0 acknowledges and 1 rejects. An armed override (`ack_once_set_i`) makes the next response the inverse of `ack_pol_i`, and the override then disarms itself, so `ack_once_o` returns to 0.
- R11: A repeated Start restarts header decoding. The sequence 7'h7E with write, then a repeated Start, then the static address with write, opens a normal write transfer.
- R12: The engine changes its SDA drive only while synchronized SCL is low. Releasing SDA is allowed at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL sample |
| sda_i | input | 1 | Raw SDA sample (wired bus value) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| static_addr_i | input | 7 | Static target address |
| dyn_addr_valid_i | input | 1 | A dynamic address is held |
| sa_sdr_en_i | input | 1 | Static-address SDR option enabled |
| mode_o | output | 2 | 00 legacy I2C, 01 SDR |
| ack_pol_i | input | 1 | Standing response: 0 ACK, 1 NACK |
| ack_once_set_i | input | 1 | Pulse arms the one-shot override |
| ack_once_o | output | 1 | One-shot override armed |
| rx_data_o | output | 8 | Receive buffer byte |
| rx_full_o | output | 1 | Receive buffer holds a byte |
| rx_pop_i | input | 1 | Pulse empties the receive buffer |
| tx_data_i | input | 8 | Byte to load into the transmit buffer |
| tx_load_i | input | 1 | Pulse loads the transmit buffer |
| tx_empty_o | output | 1 | Transmit buffer is empty |
| flag_clr_i | input | 1 | Pulse clears all flags and the direction code |
| addr_match_o | output | 1 | Header accepted |
| tcomp_o | output | 1 | Transfer complete |
| cack_o | output | 1 | Controller acknowledged a read byte |
| cnack_o | output | 1 | Controller rejected a read byte |
| tx_under_o | output | 1 | Read byte sent from an empty buffer |
| rx_over_o | output | 1 | Write byte arrived while the buffer was full |
| dir_o | output | 2 | Direction code: 10 write, 01 read |

## Verification
Some properties are checked by assertions on every cycle:
- the direction code never has both bits set;
- a header acceptance is never flagged outside legacy mode;
- the one-shot override disarms after any response it shapes;
- a receive overrun is raised only while the buffer is full;
- SDA is released while the engine is silenced;
- SDA drive changes only while SCL is low.

The acknowledge decisions and the bytes that reach the bus or the receive buffer can only be shown by the bench scenarios, which play a controller on the bus. The same holds for the underrun filler byte, the rejection of the static address in SDR mode, and header decoding after a repeated Start.

// File: rtl/i2c_lt_pkg.sv
package i2c_lt_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_HACK,
      ST_WDATA,
      ST_WACK,
      ST_RDATA,
      ST_RACK,
      ST_MUTE
   } lt_state_t;

   localparam logic [1:0] DIR_NONE  = 2'b00;
   localparam logic [1:0] DIR_WRITE = 2'b10;
   localparam logic [1:0] DIR_READ  = 2'b01;

   localparam logic [1:0] MODE_LEGACY = 2'b00;
   localparam logic [1:0] MODE_SDR    = 2'b01;
endpackage

// File: rtl/i2c_lt_line_sync.sv
module i2c_lt_line_sync #(
   parameter int STAGES    = 2,
   parameter bit FILTER_EN = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s_o,
   output logic sda_s_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_lt_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_pipe, sda_pipe;
   logic scl_c, sda_c, scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      end
   end

   if (FILTER_EN) begin : g_filter
      logic scl_h, sda_h, scl_f, sda_f;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scl_h <= 1'b1;
            sda_h <= 1'b1;
            scl_f <= 1'b1;
            sda_f <= 1'b1;
         end else begin
            scl_h <= scl_pipe[STAGES-1];
            sda_h <= sda_pipe[STAGES-1];
            if (scl_h == scl_pipe[STAGES-1]) scl_f <= scl_h;
            if (sda_h == sda_pipe[STAGES-1]) sda_f <= sda_h;
         end
      end
      assign scl_c = scl_f;
      assign sda_c = sda_f;
   end else begin : g_direct
      assign scl_c = scl_pipe[STAGES-1];
      assign sda_c = sda_pipe[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_c;
         sda_p <= sda_c;
      end
   end

   assign scl_s_o    = scl_c;
   assign sda_s_o    = sda_c;
   assign scl_rise_o = scl_c & ~scl_p;
   assign scl_fall_o = ~scl_c & scl_p;
   assign start_o    = scl_c & scl_p & sda_p & ~sda_c;
   assign stop_o     = scl_c & scl_p & ~sda_p & sda_c;
endmodule

// File: rtl/i2c_lt_ack_ctrl.sv
module i2c_lt_ack_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic pol_i,
   input  logic arm_i,
   input  logic use_i,
   output logic armed_o,
   output logic nack_o
);
   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      armed_q <= 1'b0;
      else if (arm_i)  armed_q <= 1'b1;
      else if (use_i)  armed_q <= 1'b0;
   end

   assign armed_o = armed_q;
   assign nack_o  = armed_q ? ~pol_i : pol_i;

   // R10: a response shaped while armed leaves the override disarmed
   p_oneshot_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (use_i && !arm_i) |=> !armed_q);
endmodule

// File: rtl/i2c_lt_engine.sv
module i2c_lt_engine
   import i2c_lt_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              legacy_ok,
   input  logic              tx_empty,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              rx_full,
   input  logic              nack_resp,
   output logic              ack_use,
   output logic              sda_oe,
   output logic              ev_hdr,
   output logic              ev_rnw,
   output logic              ev_rx_byte,
   output logic [DATA_W-1:0] rx_byte,
   output logic              ev_rx_over,
   output logic              ev_tx_pop,
   output logic              ev_tx_under,
   output logic              ev_cack,
   output logic              ev_cnack,
   output logic              ev_tcomp
);
   localparam int BIT_W = $clog2(DATA_W + 1);

   if (ADDR_W + 1 != DATA_W) begin : g_bad_width
      $error("i2c_lt_engine: header must be ADDR_W bits plus R/W");
   end

   lt_state_t         st_q;
   logic [DATA_W-1:0] sh_q;
   logic [BIT_W-1:0]  cnt_q;
   logic              oe_q, ack_q, rnw_q, active_q;

   logic quiet, byte_done, hdr_hit, hdr_can, dec_hdr, dec_wr;
   logic hack_rd, rack_next;
   logic [DATA_W-1:0] next_tx;

   always_comb begin
      quiet       = !start_det && !stop_det;
      byte_done   = scl_fall && (cnt_q == BIT_W'(DATA_W));
      hdr_hit     = legacy_ok && (sh_q[DATA_W-1:1] == own_addr);
      hdr_can     = hdr_hit && !(sh_q[0] && tx_empty);
      dec_hdr     = quiet && (st_q == ST_ADDR) && byte_done;
      dec_wr      = quiet && (st_q == ST_WDATA) && byte_done;
      ack_use     = (dec_hdr && hdr_can) || (dec_wr && !rx_full);
      ev_hdr      = dec_hdr && hdr_can && !nack_resp;
      ev_rnw      = sh_q[0];
      ev_rx_byte  = dec_wr && !rx_full && !nack_resp;
      rx_byte     = sh_q;
      ev_rx_over  = dec_wr && rx_full;
      hack_rd     = quiet && (st_q == ST_HACK) && scl_fall && ack_q && rnw_q;
      rack_next   = quiet && (st_q == ST_RACK) && scl_fall;
      ev_tx_pop   = hack_rd || (rack_next && !tx_empty);
      ev_tx_under = rack_next && tx_empty;
      ev_cack     = quiet && (st_q == ST_RACK) && scl_rise && !sda_s;
      ev_cnack    = quiet && (st_q == ST_RACK) && scl_rise && sda_s;
      ev_tcomp    = (start_det || stop_det) && active_q;
      next_tx     = tx_empty ? '1 : tx_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         sh_q     <= '0;
         cnt_q    <= '0;
         oe_q     <= 1'b0;
         ack_q    <= 1'b0;
         rnw_q    <= 1'b0;
         active_q <= 1'b0;
      end else if (start_det) begin
         st_q     <= ST_ADDR;
         cnt_q    <= '0;
         oe_q     <= 1'b0;
         active_q <= 1'b0;
      end else if (stop_det) begin
         st_q     <= ST_IDLE;
         oe_q     <= 1'b0;
         active_q <= 1'b0;
      end else begin
         unique case (st_q)
            ST_ADDR, ST_WDATA: begin
               if (scl_rise) begin
                  sh_q  <= {sh_q[DATA_W-2:0], sda_s};
                  cnt_q <= cnt_q + 1'b1;
               end else if (byte_done) begin
                  if (st_q == ST_ADDR) begin
                     oe_q     <= ev_hdr;
                     ack_q    <= ev_hdr;
                     rnw_q    <= sh_q[0];
                     active_q <= ev_hdr;
                     st_q     <= ST_HACK;
                  end else begin
                     oe_q  <= ev_rx_byte;
                     ack_q <= ev_rx_byte;
                     st_q  <= ST_WACK;
                  end
               end
            end
            ST_HACK, ST_WACK: begin
               if (scl_fall) begin
                  cnt_q <= '0;
                  if (!ack_q) begin
                     oe_q <= 1'b0;
                     st_q <= ST_MUTE;
                  end else if (st_q == ST_HACK && rnw_q) begin
                     sh_q <= tx_data;
                     oe_q <= ~tx_data[DATA_W-1];
                     st_q <= ST_RDATA;
                  end else begin
                     oe_q <= 1'b0;
                     st_q <= ST_WDATA;
                  end
               end
            end
            ST_RDATA: begin
               if (scl_rise) begin
                  sh_q  <= {sh_q[DATA_W-2:0], 1'b1};
                  cnt_q <= cnt_q + 1'b1;
               end else if (scl_fall) begin
                  if (cnt_q == BIT_W'(DATA_W)) begin
                     oe_q <= 1'b0;
                     st_q <= ST_RACK;
                  end else begin
                     oe_q <= ~sh_q[DATA_W-1];
                  end
               end
            end
            ST_RACK: begin
               if (ev_cnack) begin
                  st_q <= ST_MUTE;
               end else if (rack_next) begin
                  sh_q  <= next_tx;
                  oe_q  <= ~next_tx[DATA_W-1];
                  cnt_q <= '0;
                  st_q  <= ST_RDATA;
               end
            end
            ST_MUTE: oe_q <= 1'b0;
            default: ;
         endcase
      end
   end

   assign sda_oe = oe_q;

   // R12: drive only changes while SCL is low (release is always allowed)
   p_sda_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_q != $past(oe_q)) |-> (!scl_s || !oe_q));
   // R8: the silenced state never pulls SDA
   p_mute_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_MUTE) |-> !oe_q);
endmodule

// File: rtl/i2c_legacy_target.sv
module i2c_legacy_target
   import i2c_lt_pkg::*;
#(
   parameter int ADDR_W      = 7,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit FILTER_EN   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   input  logic [ADDR_W-1:0] static_addr_i,
   input  logic              dyn_addr_valid_i,
   input  logic              sa_sdr_en_i,
   output logic [1:0]        mode_o,
   input  logic              ack_pol_i,
   input  logic              ack_once_set_i,
   output logic              ack_once_o,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              rx_full_o,
   input  logic              rx_pop_i,
   input  logic [DATA_W-1:0] tx_data_i,
   input  logic              tx_load_i,
   output logic              tx_empty_o,
   input  logic              flag_clr_i,
   output logic              addr_match_o,
   output logic              tcomp_o,
   output logic              cack_o,
   output logic              cnack_o,
   output logic              tx_under_o,
   output logic              rx_over_o,
   output logic [1:0]        dir_o
);
   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic legacy_ok, nack_resp, ack_use;
   logic ev_hdr, ev_rnw, ev_rx_byte, ev_rx_over, ev_tx_pop, ev_tx_under;
   logic ev_cack, ev_cnack, ev_tcomp;
   logic [DATA_W-1:0] rx_byte, rx_q, tx_q;
   logic rx_full_q, tx_full_q;
   logic match_q, tcomp_q, cack_q, cnack_q, under_q, over_q;
   logic [1:0] dir_q;

   assign legacy_ok = !dyn_addr_valid_i && !sa_sdr_en_i;
   assign mode_o    = legacy_ok ? MODE_LEGACY : MODE_SDR;

   i2c_lt_line_sync #(.STAGES(SYNC_STAGES), .FILTER_EN(FILTER_EN)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s_o(scl_s), .sda_s_o(sda_s), .scl_rise_o(scl_rise),
      .scl_fall_o(scl_fall), .start_o(start_det), .stop_o(stop_det));

   i2c_lt_ack_ctrl u_ack (
      .clk(clk), .rst_n(rst_n), .pol_i(ack_pol_i), .arm_i(ack_once_set_i),
      .use_i(ack_use), .armed_o(ack_once_o), .nack_o(nack_resp));

   i2c_lt_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
      .stop_det(stop_det), .own_addr(static_addr_i), .legacy_ok(legacy_ok),
      .tx_empty(!tx_full_q), .tx_data(tx_q), .rx_full(rx_full_q),
      .nack_resp(nack_resp), .ack_use(ack_use), .sda_oe(sda_oe_o),
      .ev_hdr(ev_hdr), .ev_rnw(ev_rnw), .ev_rx_byte(ev_rx_byte),
      .rx_byte(rx_byte), .ev_rx_over(ev_rx_over), .ev_tx_pop(ev_tx_pop),
      .ev_tx_under(ev_tx_under), .ev_cack(ev_cack), .ev_cnack(ev_cnack),
      .ev_tcomp(ev_tcomp));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q      <= '0;
         rx_full_q <= 1'b0;
         tx_q      <= '0;
         tx_full_q <= 1'b0;
      end else begin
         if (ev_rx_byte) begin
            rx_q      <= rx_byte;
            rx_full_q <= 1'b1;
         end else if (rx_pop_i) begin
            rx_full_q <= 1'b0;
         end
         if (tx_load_i) begin
            tx_q      <= tx_data_i;
            tx_full_q <= 1'b1;
         end else if (ev_tx_pop) begin
            tx_full_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_q <= 1'b0; tcomp_q <= 1'b0; cack_q <= 1'b0;
         cnack_q <= 1'b0; under_q <= 1'b0; over_q <= 1'b0;
         dir_q   <= DIR_NONE;
      end else if (flag_clr_i) begin
         match_q <= 1'b0; tcomp_q <= 1'b0; cack_q <= 1'b0;
         cnack_q <= 1'b0; under_q <= 1'b0; over_q <= 1'b0;
         dir_q   <= DIR_NONE;
      end else begin
         if (ev_hdr) begin
            match_q <= 1'b1;
            dir_q   <= ev_rnw ? DIR_READ : DIR_WRITE;
         end
         if (ev_tcomp)    tcomp_q <= 1'b1;
         if (ev_cack)     cack_q  <= 1'b1;
         if (ev_cnack)    cnack_q <= 1'b1;
         if (ev_tx_under) under_q <= 1'b1;
         if (ev_rx_over)  over_q  <= 1'b1;
      end
   end

   assign rx_data_o    = rx_q;
   assign rx_full_o    = rx_full_q;
   assign tx_empty_o   = !tx_full_q;
   assign addr_match_o = match_q;
   assign tcomp_o      = tcomp_q;
   assign cack_o       = cack_q;
   assign cnack_o      = cnack_q;
   assign tx_under_o   = under_q;
   assign rx_over_o    = over_q;
   assign dir_o        = dir_q;

   // R3: the direction code is never both bits at once
   p_dir_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dir_q));
   // R2: an acceptance is only flagged in legacy mode
   p_match_legacy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(match_q) |-> $past(legacy_ok));
   // R5: overrun only raised against a full receive buffer
   p_over_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(over_q) |-> $past(rx_full_q));
endmodule

// File: tb/i2c_legacy_target_tb.sv
module i2c_legacy_target_tb_top;
   localparam int H = 20;
   localparam logic [6:0] OWN = 7'h5A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1, sda_m = 1'b1;
   logic sda_oe;
   wire  sda_bus = sda_m & ~sda_oe;
   logic dyn_v = 1'b0, sa_sdr = 1'b0, ack_pol = 1'b0, once_set = 1'b0;
   logic rx_pop = 1'b0, tx_load = 1'b0, fclr = 1'b0;
   logic [7:0] tx_d = 8'h00;
   logic [1:0] mode, dir;
   logic once, rx_full, tx_empty, amatch, tcomp, cack, cnack, under, over;
   logic [7:0] rx_d;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   i2c_legacy_target dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
      .static_addr_i(OWN), .dyn_addr_valid_i(dyn_v), .sa_sdr_en_i(sa_sdr),
      .mode_o(mode), .ack_pol_i(ack_pol), .ack_once_set_i(once_set),
      .ack_once_o(once), .rx_data_o(rx_d), .rx_full_o(rx_full), .rx_pop_i(rx_pop),
      .tx_data_i(tx_d), .tx_load_i(tx_load), .tx_empty_o(tx_empty),
      .flag_clr_i(fclr), .addr_match_o(amatch), .tcomp_o(tcomp), .cack_o(cack),
      .cnack_o(cnack), .tx_under_o(under), .rx_over_o(over), .dir_o(dir));

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic pulse(ref logic s);
      s = 1'b1; wt(1); s = 1'b0; wt(1);
   endtask

   task automatic bus_start;
      sda_m = 1'b1; wt(H); scl = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl = 1'b0; wt(2);
   endtask

   task automatic bus_stop;
      sda_m = 1'b0; wt(H); scl = 1'b1; wt(H); sda_m = 1'b1; wt(H);
   endtask

   task automatic bit_x(input logic b, output logic r);
      sda_m = b; wt(H); scl = 1'b1; wt(H / 2); r = sda_bus; wt(H / 2);
      scl = 1'b0; wt(2);
   endtask

   task automatic send_byte(input logic [7:0] d, output logic acked);
      logic r;
      for (int i = 7; i >= 0; i--) bit_x(d[i], r);
      bit_x(1'b1, r);
      acked = !r;
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] d);
      logic r;
      for (int i = 7; i >= 0; i--) begin
         bit_x(1'b1, r);
         d[i] = r;
      end
      bit_x(!give_ack, r);
   endtask

   task automatic t_reset;
      chk("R2 reset mode", mode, 2'b00);
      chk("R3 reset dir", dir, 2'b00);
      chk("R12 reset sda drive", sda_oe, 0);
      chk("R6 reset tx empty", tx_empty, 1);
      chk("R4 reset rx full", rx_full, 0);
      chk("R1 reset match", amatch, 0);
   endtask

   task automatic t_write;
      logic a;
      pulse(fclr);
      bus_start; send_byte({OWN, 1'b0}, a);
      chk("R1 write header ack", a, 1);
      chk("R1 match flag", amatch, 1);
      chk("R3 dir write", dir, 2'b10);
      send_byte(8'hC3, a);
      chk("R4 data ack", a, 1);
      chk("R4 rx data", rx_d, 8'hC3);
      chk("R4 rx full", rx_full, 1);
      pulse(rx_pop);
      chk("R4 pop empties", rx_full, 0);
      send_byte(8'h3C, a);
      chk("R4 second byte", rx_d, 8'h3C);
      chk("R9 no tcomp mid transfer", tcomp, 0);
      bus_stop; wt(10);
      chk("R9 tcomp after stop", tcomp, 1);
      chk("R3 dir sticky after stop", dir, 2'b10);
      pulse(rx_pop);
   endtask

   task automatic t_reject;
      logic a;
      pulse(fclr);
      bus_start; send_byte({7'h33, 1'b0}, a); bus_stop; wt(10);
      chk("R2 other address nack", a, 0);
      chk("R2 no match flag", amatch, 0);
      chk("R9 no tcomp on rejected", tcomp, 0);
      dyn_v = 1'b1; wt(2);
      chk("R2 mode sdr", mode, 2'b01);
      bus_start; send_byte({OWN, 1'b0}, a); bus_stop; wt(10);
      chk("R2 static nack with dynamic", a, 0);
      dyn_v = 1'b0; sa_sdr = 1'b1; wt(2);
      chk("R2 mode sdr option", mode, 2'b01);
      bus_start; send_byte({OWN, 1'b0}, a); bus_stop; wt(10);
      chk("R2 static nack sdr option", a, 0);
      chk("R2 match still clear", amatch, 0);
      chk("R3 dir untouched", dir, 2'b00);
      sa_sdr = 1'b0; wt(2);
   endtask

   task automatic t_read;
      logic a;
      logic [7:0] d;
      pulse(fclr);
      bus_start; send_byte({OWN, 1'b1}, a); bus_stop; wt(10);
      chk("R6 read header nack when empty", a, 0);
      tx_d = 8'hA5; pulse(tx_load);
      bus_start; send_byte({OWN, 1'b1}, a);
      chk("R6 read header ack", a, 1);
      chk("R3 dir read", dir, 2'b01);
      recv_byte(1'b1, d);
      chk("R6 first byte", d, 8'hA5);
      chk("R6 tx emptied", tx_empty, 1);
      chk("R7 cack flag", cack, 1);
      recv_byte(1'b0, d);
      chk("R7 underrun filler", d, 8'hFF);
      chk("R7 underrun flag", under, 1);
      chk("R8 cnack flag", cnack, 1);
      wt(H);
      chk("R8 sda released", sda_oe, 0);
      chk("R9 tcomp waits stop", tcomp, 0);
      bus_stop; wt(10);
      chk("R9 tcomp after read", tcomp, 1);
   endtask

   task automatic t_overrun;
      logic a;
      pulse(fclr);
      bus_start; send_byte({OWN, 1'b0}, a);
      send_byte(8'h11, a);
      chk("R4 first stored", rx_d, 8'h11);
      send_byte(8'h22, a);
      chk("R5 overrun nack", a, 0);
      chk("R5 overrun flag", over, 1);
      chk("R5 data kept", rx_d, 8'h11);
      bus_stop; wt(10);
      pulse(rx_pop);
   endtask

   task automatic t_oneshot;
      logic a;
      pulse(fclr);
      ack_pol = 1'b1;
      bus_start; send_byte({OWN, 1'b0}, a); bus_stop; wt(10);
      chk("R10 standing nack", a, 0);
      pulse(once_set);
      chk("R10 armed", once, 1);
      bus_start; send_byte({OWN, 1'b0}, a);
      chk("R10 one-shot inverts to ack", a, 1);
      chk("R10 one-shot disarmed", once, 0);
      send_byte(8'h5E, a);
      chk("R10 back to standing nack", a, 0);
      chk("R10 byte not stored", rx_full, 0);
      bus_stop; wt(10);
      ack_pol = 1'b0;
   endtask

   task automatic t_restart;
      logic a;
      pulse(fclr);
      bus_start; send_byte({7'h7E, 1'b0}, a);
      chk("R11 broadcast not taken", a, 0);
      bus_start; send_byte({OWN, 1'b0}, a);
      chk("R11 header after restart ack", a, 1);
      send_byte(8'h81, a);
      chk("R11 data after restart", rx_d, 8'h81);
      bus_start; wt(10);
      chk("R9 tcomp on restart", tcomp, 1);
      bus_stop; wt(10);
      pulse(fclr);
      chk("R3 dir cleared", dir, 2'b00);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      wt(5); rst_n = 1'b1; wt(5);
      t_reset;
      t_write;
      t_reject;
      t_read;
      t_overrun;
      t_oneshot;
      t_restart;
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule